// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block turns a single internal request (address, write data, direction, two byte enables, an address-stretch flag and a programmable wait count) into one complete cycle on an external bus where address and data share the same wires. A rising address strobe marks the address phase. A read strobe or a pair of byte-lane write strobes then marks the data phase. An active-low wait input from the external device can lengthen that phase.

The sequencer runs on a clock at twice the external system rate. Each clock period is therefore one half-tick (0.5·T), and every strobe edge falls on a clock edge. All bus outputs come straight from flip-flops. A request is accepted only while the block is idle. The cycle ends with a one-cycle completion pulse, which for reads comes with the data captured as the read strobe rose.

Top module: `mxb_bus_ctrl`

## Requirements
- R1: After reset the address strobe is low, all three active-low data strobes are high, the bus output enable is low, the completion pulse is low and the request-ready output is high.
- R2: The address strobe stays high for 1 half-tick, or for 3 half-ticks when the request's address-stretch flag is set. Throughout that time the request address is driven on the bus with the output enable high.
- R3: After the address strobe falls, the address stays driven for exactly 1 half-tick. The data strobe falls at the end of that half-tick.
- R4: A data strobe stays low for 3 + 2·n half-ticks. Here n is the larger of the programmable wait count and the number of consecutive low samples of the wait input. The wait input is first sampled 2 half-ticks after the strobe falls and again every 2 half-ticks while waiting. The strobe rises only after a high sample.
- R5: On a read the output enable is low while the read strobe is low. The returned data equals the bus input value present just before the read strobe rises.
- R6: On a write the write data is driven, with the output enable high, from the write strobe fall until 1 half-tick after the write strobe rises. The bus is then released.
- R7: Byte enable bit 0 selects the low-lane write strobe and bit 1 selects the high-lane write strobe. A lane whose enable is clear keeps its strobe high.
- R8: After a read strobe rises, at least 1 half-tick passes before the next address strobe rises. After a write strobe rises, at least 3 half-ticks pass.
- R9: Request-ready is low from acceptance until the cycle in which the completion pulse is high. Each request produces exactly one completion pulse, one clock long.
- R10: The address strobe, the read strobe and the write strobes are never active at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the external system rate |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_addr | input | W | Address to place on the bus |
| req_wdata | input | W | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte-lane enables, bit 0 low lane, bit 1 high lane |
| req_addr_wait | input | 1 | Stretch the address phase by one T |
| req_wait_cnt | input | WCW | Programmable wait cycles |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | W | Data captured on the read strobe rise |
| bus_astb | output | 1 | Address strobe, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wrl_n | output | 1 | Low-lane write strobe, active low |
| bus_wrh_n | output | 1 | High-lane write strobe, active low |
| bus_ad_out | output | W | Multiplexed address/data output |
| bus_ad_oe | output | 1 | Output enable for bus_ad_out |
| bus_ad_in | input | W | Multiplexed bus input |
| bus_wait_n | input | 1 | External wait request, active low |

## Verification
A wrong phase counter or state shows up within a few half-ticks. It appears as an address strobe pulse of the wrong width, a missing or extra half-tick between the strobe fall and the data strobe fall, or a data strobe whose low width is not 3 + 2·n. A lost or miscounted wait shows up at the strobe rise of the same transfer. A stale latched direction or byte enable shows up as the wrong strobe or lane going low, or as the bus being driven during a read. Recovery errors appear only on the next transfer, as a short gap between the strobe rise and the following address strobe, so back-to-back transfers are run on purpose.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_HOLD,
    ST_STB,
    ST_TAIL,
    ST_REC
  } mxb_state_e;

  // half-tick phase lengths, counted as "extra ticks beyond the first"
  localparam logic [1:0] ADDR_STRETCH = 2'd2;  // one extra T
  localparam logic [1:0] STB_SAMPLE   = 2'd1;  // sample 1 T after fall
  localparam logic [1:0] WR_RECOVER   = 2'd1;  // data hold + gap
endpackage

// File: rtl/mxb_wait_unit.sv
module mxb_wait_unit #(
  parameter int WCW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [WCW-1:0] load_val,
  input  logic           decide,
  input  logic           wait_n,
  output logic           extend
);
  logic [WCW-1:0] remain_q;

  // programmable and pin-driven waits run side by side: longer one wins
  assign extend = (remain_q != '0) || !wait_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (decide && remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end
endmodule

// File: rtl/mxb_strobe_gen.sv
module mxb_strobe_gen (
  input  logic       clk,
  input  logic       rst,
  input  logic       astb_nxt,
  input  logic       stb_nxt,
  input  logic       is_wr,
  input  logic [1:0] be,
  output logic       astb,
  output logic       rd_n,
  output logic       wrl_n,
  output logic       wrh_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      astb  <= 1'b0;
      rd_n  <= 1'b1;
      wrl_n <= 1'b1;
      wrh_n <= 1'b1;
    end else begin
      astb  <= astb_nxt;
      rd_n  <= !(stb_nxt && !is_wr);
      wrl_n <= !(stb_nxt && is_wr && be[0]);
      wrh_n <= !(stb_nxt && is_wr && be[1]);
    end
  end

  // R10: only one kind of strobe active at a time
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(astb && (!rd_n || !wrl_n || !wrh_n)) && !(!rd_n && (!wrl_n || !wrh_n)));
endmodule

// File: rtl/mxb_ad_path.sv
module mxb_ad_path #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         drv_addr,
  input  logic         drv_data,
  input  logic [W-1:0] addr,
  input  logic [W-1:0] wdata,
  input  logic         capture,
  input  logic [W-1:0] ad_in,
  output logic [W-1:0] ad_out,
  output logic         oe,
  output logic [W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ad_out <= '0;
      oe     <= 1'b0;
      rdata  <= '0;
    end else begin
      oe <= drv_addr || drv_data;
      if (drv_addr)      ad_out <= addr;
      else if (drv_data) ad_out <= wdata;
      if (capture)       rdata  <= ad_in;
    end
  end
endmodule

// File: rtl/mxb_bus_ctrl.sv
module mxb_bus_ctrl
  import mxb_pkg::*;
#(
  parameter int W   = 16,
  parameter int WCW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [W-1:0]   req_addr,
  input  logic [W-1:0]   req_wdata,
  input  logic           req_write,
  input  logic [1:0]     req_be,
  input  logic           req_addr_wait,
  input  logic [WCW-1:0] req_wait_cnt,
  output logic           rsp_done,
  output logic [W-1:0]   rsp_rdata,
  output logic           bus_astb,
  output logic           bus_rd_n,
  output logic           bus_wrl_n,
  output logic           bus_wrh_n,
  output logic [W-1:0]   bus_ad_out,
  output logic           bus_ad_oe,
  input  logic [W-1:0]   bus_ad_in,
  input  logic           bus_wait_n
);
  mxb_state_e st_q, st_n;
  logic [1:0] cnt_q, cnt_n;
  logic [W-1:0] lat_addr, lat_wdata;
  logic       lat_wr, lat_aw;
  logic [1:0] lat_be;
  logic       done_q;
  logic       accept, decide, extend;
  logic       cur_wr;
  logic [1:0] cur_be;
  logic [W-1:0] cur_addr, cur_wdata;
  logic       stb_nxt, drv_addr, drv_data;

  assign accept    = (st_q == ST_IDLE) && req_valid;
  assign decide    = (st_q == ST_STB) && (cnt_q == 2'd0);
  assign req_ready = (st_q == ST_IDLE);
  assign rsp_done  = done_q;

  // outputs are registered from next state, so the incoming request is
  // used directly on the accept edge
  assign cur_wr    = (st_q == ST_IDLE) ? req_write : lat_wr;
  assign cur_be    = (st_q == ST_IDLE) ? req_be    : lat_be;
  assign cur_addr  = (st_q == ST_IDLE) ? req_addr  : lat_addr;
  assign cur_wdata = (st_q == ST_IDLE) ? req_wdata : lat_wdata;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        st_n  = ST_ADDR;
        cnt_n = req_addr_wait ? ADDR_STRETCH : 2'd0;
      end
      ST_ADDR: if (cnt_q == 2'd0) st_n = ST_HOLD;
               else cnt_n = cnt_q - 1'b1;
      ST_HOLD: begin
        st_n  = ST_STB;
        cnt_n = STB_SAMPLE;
      end
      ST_STB: if (cnt_q != 2'd0) cnt_n = cnt_q - 1'b1;
              else if (extend) cnt_n = STB_SAMPLE;
              else begin
                st_n  = ST_TAIL;
                cnt_n = 2'd0;
              end
      ST_TAIL: begin
        st_n  = ST_REC;
        cnt_n = cur_wr ? WR_RECOVER : 2'd0;
      end
      ST_REC: if (cnt_q == 2'd0) st_n = ST_IDLE;
              else cnt_n = cnt_q - 1'b1;
      default: begin
        st_n  = ST_IDLE;
        cnt_n = 2'd0;
      end
    endcase
  end

  assign stb_nxt  = (st_n == ST_STB) || (st_n == ST_TAIL);
  assign drv_addr = (st_n == ST_ADDR) || (st_n == ST_HOLD);
  assign drv_data = cur_wr && (stb_nxt || (st_n == ST_REC && cnt_n != 2'd0));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      cnt_q     <= 2'd0;
      done_q    <= 1'b0;
      lat_wr    <= 1'b0;
      lat_aw    <= 1'b0;
      lat_be    <= 2'b00;
      lat_addr  <= '0;
      lat_wdata <= '0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      done_q <= (st_q == ST_REC) && (cnt_q == 2'd0);
      if (accept) begin
        lat_wr    <= req_write;
        lat_aw    <= req_addr_wait;
        lat_be    <= req_be;
        lat_addr  <= req_addr;
        lat_wdata <= req_wdata;
      end
    end
  end

  mxb_wait_unit #(.WCW(WCW)) u_wait (
    .clk(clk), .rst(rst), .load(accept), .load_val(req_wait_cnt),
    .decide(decide), .wait_n(bus_wait_n), .extend(extend)
  );

  mxb_strobe_gen u_stb (
    .clk(clk), .rst(rst), .astb_nxt(st_n == ST_ADDR), .stb_nxt(stb_nxt),
    .is_wr(cur_wr), .be(cur_be), .astb(bus_astb), .rd_n(bus_rd_n),
    .wrl_n(bus_wrl_n), .wrh_n(bus_wrh_n)
  );

  mxb_ad_path #(.W(W)) u_ad (
    .clk(clk), .rst(rst), .drv_addr(drv_addr), .drv_data(drv_data),
    .addr(cur_addr), .wdata(cur_wdata), .capture(st_q == ST_TAIL),
    .ad_in(bus_ad_in), .ad_out(bus_ad_out), .oe(bus_ad_oe), .rdata(rsp_rdata)
  );

  // R2: address strobe width follows the latched stretch flag
  a_r2_astb_width: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_astb) |-> (lat_aw ? ($past(bus_astb, 2) && $past(bus_astb, 3))
                                : !$past(bus_astb, 2)));

  // R3: read strobe falls one half-tick after the address strobe
  a_r3_read_strobe_follows: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_astb) && !lat_wr) |=> $fell(bus_rd_n));

  // R4: a data strobe rises only after a high wait sample
  a_r4_rise_after_wait_high: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_rd_n) || $rose(bus_wrl_n) || $rose(bus_wrh_n)) |-> $past(bus_wait_n, 2));

  // R5: bus released while reading
  a_r5_read_released: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> !bus_ad_oe);

  // R9: completion pulse lasts one clock
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
endmodule

// File: tb/mxb_bus_ctrl_tb.sv
module mxb_bus_ctrl_tb;
  localparam int W = 16;
  localparam int WCW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [W-1:0] req_addr = '0, req_wdata = '0;
  logic req_write = 1'b0, req_addr_wait = 1'b0;
  logic [1:0] req_be = 2'b00;
  logic [WCW-1:0] req_wait_cnt = '0;
  logic rsp_done;
  logic [W-1:0] rsp_rdata;
  logic bus_astb, bus_rd_n, bus_wrl_n, bus_wrh_n, bus_ad_oe;
  logic [W-1:0] bus_ad_out;
  logic [W-1:0] bus_ad_in = '0;
  logic bus_wait_n = 1'b1;

  always #10 clk = ~clk;  // 50 MHz

  mxb_bus_ctrl #(.W(W), .WCW(WCW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .req_be(req_be), .req_addr_wait(req_addr_wait), .req_wait_cnt(req_wait_cnt),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_astb(bus_astb),
    .bus_rd_n(bus_rd_n), .bus_wrl_n(bus_wrl_n), .bus_wrh_n(bus_wrh_n),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
    .bus_wait_n(bus_wait_n)
  );

  int errors = 0;
  int checks = 0;
  int tick = 0;
  bit finished = 0;

  always @(posedge clk) tick <= tick + 1;

  // measurements of the last transfer
  int m_astb_hi, m_gap, m_low, m_low_l, m_low_h, m_oe_after, m_done;
  int m_addr_bad, m_data_bad, m_rd_oe, m_busy_ready;
  int m_rise_tick, m_astb_rise_tick;
  logic [W-1:0] m_rdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input bit wr, input logic [1:0] be, input bit aw, input int wc,
                     input int k, input logic [W-1:0] addr, input logic [W-1:0] data);
    bit seen_astb, stb_seen, rise_seen, got;
    m_astb_hi = 0; m_gap = 0; m_low = 0; m_low_l = 0; m_low_h = 0;
    m_oe_after = 0; m_done = 0; m_addr_bad = 0; m_data_bad = 0;
    m_rd_oe = 0; m_busy_ready = 0; m_rise_tick = 0; m_astb_rise_tick = 0;
    seen_astb = 0; stb_seen = 0; rise_seen = 0; got = 0;
    req_write = wr; req_be = be; req_addr_wait = aw;
    req_wait_cnt = WCW'(wc); req_addr = addr; req_wdata = data;
    bus_ad_in = data;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 200 && !got; i++) begin
      if (bus_astb) begin
        if (!seen_astb) m_astb_rise_tick = tick;
        seen_astb = 1;
        m_astb_hi++;
        if (!(bus_ad_oe && bus_ad_out == addr)) m_addr_bad++;
      end
      if (!bus_rd_n || !bus_wrl_n || !bus_wrh_n) begin
        stb_seen = 1;
        m_low++;
        if (!bus_wrl_n) m_low_l++;
        if (!bus_wrh_n) m_low_h++;
        if (wr && !(bus_ad_oe && bus_ad_out == data)) m_data_bad++;
        if (!wr && bus_ad_oe) m_rd_oe++;
        bus_wait_n = (m_low > 2 * k);
      end else begin
        bus_wait_n = 1'b1;
        if (!bus_astb && seen_astb && !stb_seen) begin
          m_gap++;
          if (!(bus_ad_oe && bus_ad_out == addr)) m_addr_bad++;
        end
        if (stb_seen) begin
          if (!rise_seen) m_rise_tick = tick;
          rise_seen = 1;
          if (bus_ad_oe) begin
            m_oe_after++;
            if (wr && bus_ad_out != data) m_data_bad++;
          end
        end
      end
      if (rsp_done) begin
        m_done++;
        m_rdata = rsp_rdata;
        got = 1;
      end else if (req_ready) begin
        m_busy_ready++;
      end
      if (!got) @(negedge clk);
    end
    chk(got, "R9 done seen", m_done, 1);
  endtask

  task automatic t_reset;
    chk(bus_astb == 1'b0, "R1 astb", bus_astb, 0);
    chk({bus_rd_n, bus_wrl_n, bus_wrh_n} == 3'b111, "R1 strobes", {bus_rd_n, bus_wrl_n, bus_wrh_n}, 7);
    chk(bus_ad_oe == 1'b0, "R1 oe", bus_ad_oe, 0);
    chk(rsp_done == 1'b0, "R1 done", rsp_done, 0);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
  endtask

  task automatic t_read_basic;
    run(0, 2'b00, 0, 0, 0, 16'h1234, 16'hBEEF);
    chk(m_astb_hi == 1, "R2 astb width", m_astb_hi, 1);
    chk(m_addr_bad == 0, "R2 address driven", m_addr_bad, 0);
    chk(m_gap == 1, "R3 hold gap", m_gap, 1);
    chk(m_low == 3, "R4 read low width n=0", m_low, 3);
    chk(m_rd_oe == 0, "R5 bus released", m_rd_oe, 0);
    chk(m_rdata == 16'hBEEF, "R5 read data", m_rdata, 16'hBEEF);
    chk(m_busy_ready == 0, "R9 ready low while busy", m_busy_ready, 0);
  endtask

  task automatic t_read_addr_wait;
    run(0, 2'b00, 1, 2, 0, 16'h0F0F, 16'h5A5A);
    chk(m_astb_hi == 3, "R2 stretched astb", m_astb_hi, 3);
    chk(m_gap == 1, "R3 hold gap stretched", m_gap, 1);
    chk(m_low == 7, "R4 prog wait 2", m_low, 7);
    chk(m_rdata == 16'h5A5A, "R5 read data", m_rdata, 16'h5A5A);
  endtask

  task automatic t_write_low;
    run(1, 2'b01, 0, 1, 0, 16'h00A0, 16'hC0DE);
    chk(m_low == 5, "R4 write low width n=1", m_low, 5);
    chk(m_low_l == 5, "R7 low lane", m_low_l, 5);
    chk(m_low_h == 0, "R7 high lane idle", m_low_h, 0);
    chk(m_data_bad == 0, "R6 write data", m_data_bad, 0);
    chk(m_oe_after == 1, "R6 data hold", m_oe_after, 1);
    chk(m_gap == 1, "R3 write hold gap", m_gap, 1);
  endtask

  task automatic t_write_high_pin;
    run(1, 2'b10, 0, 0, 2, 16'h00B0, 16'h7E57);
    chk(m_low == 7, "R4 pin wait 2", m_low, 7);
    chk(m_low_h == 7, "R7 high lane", m_low_h, 7);
    chk(m_low_l == 0, "R7 low lane idle", m_low_l, 0);
    chk(m_data_bad == 0, "R6 write data", m_data_bad, 0);
  endtask

  task automatic t_wait_max;
    run(0, 2'b00, 0, 3, 1, 16'h0101, 16'h1111);
    chk(m_low == 9, "R4 max prog>pin", m_low, 9);
    run(0, 2'b00, 0, 1, 3, 16'h0202, 16'h2222);
    chk(m_low == 9, "R4 max pin>prog", m_low, 9);
    run(1, 2'b11, 0, 0, 0, 16'h0303, 16'h3333);
    chk(m_low_l == 3 && m_low_h == 3, "R7 both lanes", m_low_l + m_low_h, 6);
  endtask

  task automatic t_turnaround;
    int prev;
    run(0, 2'b00, 0, 0, 0, 16'h1000, 16'hAAAA);
    prev = m_rise_tick;
    run(0, 2'b00, 0, 0, 0, 16'h2000, 16'h5555);
    chk(m_astb_rise_tick - prev >= 1, "R8 read turnaround", m_astb_rise_tick - prev, 1);
    chk(m_rdata == 16'h5555, "R5 back-to-back read data", m_rdata, 16'h5555);
    run(1, 2'b11, 0, 0, 0, 16'h3000, 16'h1357);
    prev = m_rise_tick;
    run(0, 2'b00, 0, 0, 0, 16'h4000, 16'h2468);
    chk(m_astb_rise_tick - prev >= 3, "R8 write turnaround", m_astb_rise_tick - prev, 3);
    chk(m_addr_bad == 0, "R2 address after write", m_addr_bad, 0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_basic();
    @(negedge clk);
    t_read_addr_wait();
    @(negedge clk);
    t_write_low();
    @(negedge clk);
    t_write_high_pin();
    @(negedge clk);
    t_wait_max();
    @(negedge clk);
    t_turnaround();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule